// File: doc/BRIEF.md
# Next-PC Instruction Fetch Unit

This block owns the program counter of a single-cycle processor. It drives the current PC out as the instruction address, and on every rising clock edge it loads the address of the next instruction. The next address comes from one of three sources. The default is the sequential step of one 32-bit word. The second is a PC-relative branch, taken only when the decoder marks a branch and the external comparator reports equality. The third is a pseudo-direct jump, which replaces the low 28 bits of the PC with a 26-bit word index.

The block has a thin top over two modules. The control module turns the decoder flags into a pair of select strobes. The datapath module holds the PC register, a dedicated adder for the sequential step, a sign-extend-and-shift path with its own branch adder, and the jump address concatenation. The main ALU is not involved. Instruction memory, the equality comparator and instruction decoding lie outside the block.

Top module: `nextpc_unit`

## Requirements
- R1: When `rst` is 1 at a rising edge, the PC loads 0x00000000. Reset wins over every other input.
- R2: With `isBranch` 0 and `isJump` 0, the PC advances by 4 at each edge.
- R3: With `isBranch` 1, `eqFlag` 1 and `isJump` 0, the next PC is PC + 4 + (brImm sign-extended from bit 15, multiplied by 4). Negative offsets move the PC backwards.
- R4: With `isBranch` 1 and `eqFlag` 0, the next PC is PC + 4.
- R5: With `isBranch` 0, the value of `eqFlag` has no effect on the next PC.
- R6: With `isJump` 1, the next PC is {PC[31:28], jmpTgt[25:0], 2'b00}. The top four bits come from the current PC.
- R7: When `isJump` and a taken branch (`isBranch` 1 and `eqFlag` 1) are asserted together, the jump address is used.
- R8: PC bits [1:0] are always 0 once reset has been applied.
- R9: All PC arithmetic is modulo 2^32. A step from 0xFFFFFFFC gives 0x00000000, and a backward branch below zero wraps to the top of the address space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| isBranch | input | 1 | Current instruction is a conditional branch |
| eqFlag | input | 1 | Operand equality from the external comparator |
| isJump | input | 1 | Current instruction is a pseudo-direct jump |
| brImm | input | 16 | Signed branch offset, counted in words |
| jmpTgt | input | 26 | Jump word index |
| pcOut | output | 32 | Current PC, used as the instruction address |

## Verification
The bench runs several sequential stretches. It follows them with taken branches forward and backward, which shows that the offset is sign-extended and scaled by four, and with a not-taken branch, which must match the sequential step. A pattern with equality high and the branch flag low shows whether `eqFlag` leaks into the select. A jump asserted together with a taken branch shows the priority order. A backward branch that crosses zero wraps the PC to the top of the address space; the step from 0xFFFFFFFC back to 0 then checks the wrap, and a jump taken from that high region checks that the top four bits are kept. Reset applied while a jump is requested confirms that reset wins.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

  localparam int PC_WIDTH  = 32;
  localparam int IMM_WIDTH = 16;
  localparam int TGT_WIDTH = 26;

  // Select strobes from control to datapath
  typedef struct packed {
    logic takeJump;
    logic takeBranch;
  } pc_sel_t;

endpackage

// File: rtl/nextpc_ctrl.sv
module nextpc_ctrl
  import nextpc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    isBranch,
  input  logic    eqFlag,
  input  logic    isJump,
  output pc_sel_t sel
);

  // Branch select is the branch flag gated by equality; a jump masks it.
  logic branchCond;

  always_comb begin
    branchCond     = isBranch & eqFlag;
    sel.takeJump   = isJump;
    sel.takeBranch = branchCond & ~isJump;
  end

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel.takeJump, sel.takeBranch})); // R7

  AST_EQ_DONTCARE: assert property (@(posedge clk) disable iff (rst)
    !isBranch |-> !sel.takeBranch); // R5

  AST_NOEQ_NOBRANCH: assert property (@(posedge clk) disable iff (rst)
    !eqFlag |-> !sel.takeBranch); // R4

endmodule

// File: rtl/nextpc_dpath.sv
module nextpc_dpath
  import nextpc_pkg::*;
#(
  parameter int PcW  = PC_WIDTH,
  parameter int ImmW = IMM_WIDTH,
  parameter int TgtW = TGT_WIDTH
)(
  input  logic            clk,
  input  logic            rst,
  input  pc_sel_t         sel,
  input  logic [ImmW-1:0] brImm,
  input  logic [TgtW-1:0] jmpTgt,
  output logic [PcW-1:0]  pcQ
);

  localparam int HiW  = PcW - TgtW - 2;
  localparam int ExtW = PcW - ImmW - 2;
  localparam logic [PcW-1:0] StepBytes = PcW'(4);
  localparam logic [PcW-1:0] ResetPc   = '0;

  logic [PcW-1:0] seqPc;
  logic [PcW-1:0] brOff;
  logic [PcW-1:0] brPc;
  logic [PcW-1:0] jmpPc;
  logic [PcW-1:0] pcD;

  // Sequential step adder
  assign seqPc = pcQ + StepBytes;

  // Dedicated sign extend, shift by two, and branch adder
  assign brOff = {{ExtW{brImm[ImmW-1]}}, brImm, 2'b00};
  assign brPc  = seqPc + brOff;

  // Pseudo-direct jump keeps the top bits of the current PC
  assign jmpPc = {pcQ[PcW-1 -: HiW], jmpTgt, 2'b00};

  // Two-level select; jump sits last so it overrides
  always_comb begin
    pcD = seqPc;
    if (sel.takeBranch) pcD = brPc;
    if (sel.takeJump)   pcD = jmpPc;
  end

  always_ff @(posedge clk) begin
    if (rst) pcQ <= ResetPc;
    else     pcQ <= pcD;
  end

  AST_RESET_LOAD: assert property (@(posedge clk)
    rst |=> (pcQ == ResetPc)); // R1

  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
    pcQ[1:0] == 2'b00); // R8

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!sel.takeBranch && !sel.takeJump) |=> (pcQ == $past(pcQ) + StepBytes)); // R2

  AST_JUMP_HIGH_KEPT: assert property (@(posedge clk) disable iff (rst)
    sel.takeJump |=> (pcQ[PcW-1 -: HiW] == $past(pcQ[PcW-1 -: HiW]))); // R6

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 isBranch,
  input  logic                 eqFlag,
  input  logic                 isJump,
  input  logic [IMM_WIDTH-1:0] brImm,
  input  logic [TGT_WIDTH-1:0] jmpTgt,
  output logic [PC_WIDTH-1:0]  pcOut
);

  pc_sel_t sel;

  nextpc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .isBranch (isBranch),
    .eqFlag   (eqFlag),
    .isJump   (isJump),
    .sel      (sel)
  );

  nextpc_dpath #(
    .PcW  (PC_WIDTH),
    .ImmW (IMM_WIDTH),
    .TgtW (TGT_WIDTH)
  ) u_dpath (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel),
    .brImm  (brImm),
    .jmpTgt (jmpTgt),
    .pcQ    (pcOut)
  );

endmodule

// File: tb/nextpc_unit_test.sv
`timescale 1ns/1ps
module nextpc_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        isBranch = 1'b0;
  logic        eqFlag = 1'b0;
  logic        isJump = 1'b0;
  logic [15:0] brImm = '0;
  logic [25:0] jmpTgt = '0;
  logic [31:0] pcOut;

  int applied = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [31:0] expPc = '0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  nextpc_unit uut (
    .clk(clk), .rst(rst), .isBranch(isBranch), .eqFlag(eqFlag),
    .isJump(isJump), .brImm(brImm), .jmpTgt(jmpTgt), .pcOut(pcOut)
  );

  // Driver: applies one cycle of stimulus and queues the expected PC
  task automatic drive(input bit r, input bit b, input bit e, input bit j,
                       input logic [15:0] imm, input logic [25:0] tgt,
                       input string tag);
    logic [31:0] nxt;
    @(negedge clk);
    rst = r; isBranch = b; eqFlag = e; isJump = j; brImm = imm; jmpTgt = tgt;
    if (r)           nxt = 32'h0;
    else if (j)      nxt = {expPc[31:28], tgt, 2'b00};
    else if (b && e) nxt = expPc + 32'd4 + {{14{imm[15]}}, imm, 2'b00};
    else             nxt = expPc + 32'd4;
    expPc = nxt;
    expQ.push_back(nxt);
    tagQ.push_back(tag);
  endtask

  // Monitor: compares after each edge once the register has settled
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        applied++;
        if (pcOut !== e) begin
          bad++;
          $display("FAIL %s: pcOut=%h expected=%h", t, pcOut, e);
        end
        applied++;
        if (pcOut[1:0] !== 2'b00) begin
          bad++;
          $display("FAIL R8: pcOut[1:0]=%b expected=00", pcOut[1:0]);
        end
      end
    end
  end

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000 && !done) begin
        bad++;
        $display("FAIL watchdog: cycles=%0d expected=<5000", cycles);
        $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
      end
    end
  end

  initial begin
    drive(1, 0, 0, 0, 16'h0, 26'h0, "R1 reset");
    drive(1, 0, 0, 0, 16'h0, 26'h0, "R1 reset hold");
    drive(0, 0, 0, 0, 16'h0, 26'h0, "R2 step");
    drive(0, 0, 0, 0, 16'h0, 26'h0, "R2 step");
    drive(0, 0, 0, 0, 16'h0, 26'h0, "R2 step");
    drive(0, 1, 1, 0, 16'h0010, 26'h0, "R3 forward taken");
    drive(0, 1, 1, 0, 16'hFFF8, 26'h0, "R3 backward taken");
    drive(0, 1, 0, 0, 16'h0100, 26'h0, "R4 not taken");
    drive(0, 0, 1, 0, 16'h0100, 26'h0, "R5 eq ignored");
    drive(0, 0, 1, 0, 16'h8000, 26'h0, "R5 eq ignored neg imm");
    drive(0, 0, 0, 1, 16'h0, 26'h0000040, "R6 jump");
    drive(0, 1, 1, 1, 16'h0040, 26'h0000008, "R7 jump over branch");
    drive(0, 1, 1, 0, 16'hFFF6, 26'h0, "R9 wrap below zero");
    drive(0, 0, 0, 0, 16'h0, 26'h0, "R9 step to zero");
    drive(0, 1, 1, 0, 16'hFFF0, 26'h0, "R9 wrap again");
    drive(0, 0, 0, 1, 16'h0, 26'h3ABCDEF, "R6 jump keeps top bits");
    drive(0, 1, 0, 1, 16'h0, 26'h0000100, "R7 jump with untaken branch");
    drive(0, 0, 0, 0, 16'h0, 26'h0, "R2 step high");
    drive(1, 1, 1, 1, 16'h0004, 26'h1234567, "R1 reset beats jump");
    drive(0, 0, 0, 0, 16'h0, 26'h0, "R2 step after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

endmodule